// File: doc/BRIEF.md
# Double-Buffered Control Register Bank

This block holds the control registers of a signal-processing core. A parallel byte-write port loads a staged copy of each register. The logic downstream reads a separate active copy. All staged values move into the active copies in one clock edge, either on an update strobe or when the profile selection input changes value. Until then the active copies keep their old values. The address space has 26 slots and some of them are unused. Each used slot has its own byte width. Readback always shows the staged value.

Slot 0 is the main control word. Several of its bits are reserved and cannot be set. Its bit 21 is a clear command. Once that bit is set in the active copy, the block runs a fixed flush sequence. A busy output holds the filter input at zero and tells the downstream logic to ignore incoming data. At the end of the sequence an accumulator-clear pulse is issued, and the command bit drops back to 0 in both copies.

Top module: `bankreg_top`

## Requirements
- R1: Addresses 7, 8, 11, 12, 13, 23 and every address above 25 are unused. A write to one of them changes nothing, and a read from one returns 0.
- R2: Slot byte widths are as follows: slots 0–2 have 4 bytes, 3–6 have 2, 9–10 have 4, 14–21 have 3, 22 has 1, and 24–25 have 2. A write selects byte lane n with `wr_lane`, which covers bits 8n+7:8n. A write to a lane beyond the slot's width is ignored. Bits beyond the width read as 0.
- R3: A write changes only the staged copy. An active copy changes only on an edge where a transfer is made (R4, R5) or where a flush ends (R9).
- R4: An edge with `upd_strobe` high copies every staged slot into its active copy. A write in the same cycle lands in the staged copy only, and the active copy receives the value the slot had before that write.
- R5: An edge where `profile_sel` differs from its value at the previous edge (0 after reset) makes the same transfer as R4. A profile that stays the same makes no transfer.
- R6: `rd_data` shows, one cycle later, the staged value of the slot addressed by `rd_addr`.
- R7: Slot 0 bits 30, 29, 27, 26, 20:17, 15, 14 and 12 are reserved. They always read 0 and are never set in the active copy.
- R8: When active slot-0 bit 21 is 1 and no flush is running, `flush_busy` goes high on the next edge and stays high for exactly FLUSH_LEN (default 8) cycles.
- R9: The edge that ends a flush clears bit 21 in both copies of slot 0, and `acc_clr` is high for that one cycle. This clear takes priority over a write or transfer on the same edge.
- R10: A synchronous reset sets every staged and active bit to 0 and sets `flush_busy`, `acc_clr` and `rd_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write enable |
| wr_addr | input | 5 | Write slot address |
| wr_lane | input | 2 | Byte lane within the slot |
| wr_data | input | 8 | Write byte |
| rd_addr | input | 5 | Readback slot address |
| rd_data | output | 32 | Staged value of the addressed slot, one cycle later |
| upd_strobe | input | 1 | Transfer all staged values to the active copies |
| profile_sel | input | 3 | Profile select; a change in value causes a transfer |
| act_regs | output | 832 | Active copies, slot i in bits 32i+31:32i |
| flush_busy | output | 1 | Flush running; filter input held at zero |
| acc_clr | output | 1 | One-cycle accumulator clear at the end of a flush |

## Verification
Three kinds of event can fall on the same edge: a byte write, a transfer and the end of a flush. The bench drives a write together with an update strobe and checks that the active copy gets the pre-write value while the staged copy gets the new byte. It also issues an update strobe while a flush is running, so that transfers land both during the flush and on the edge where it ends. A behavioural model then decides whether the clear of bit 21 won. Every output is compared with this model on every clock.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int SLOTS    = 26;
  localparam int AW       = 5;
  localparam int DW       = 32;
  localparam int LANES    = DW / 8;
  localparam int LW       = $clog2(LANES);
  localparam int CMD_BIT  = 21;
  localparam logic [31:0] RSVD0 = 32'h6C1E_D000;

  function automatic int slot_bytes(input int a);
    if (a == 7 || a == 8 || (a >= 11 && a <= 13) || a == 23 || a > 25 || a < 0)
      return 0;
    if (a <= 2)  return 4;
    if (a <= 6)  return 2;
    if (a <= 10) return 4;
    if (a <= 21) return 3;
    if (a == 22) return 1;
    return 2;
  endfunction

  function automatic logic [DW-1:0] width_mask(input int nbytes);
    logic [DW-1:0] m;
    m = '0;
    for (int b = 0; b < LANES; b++)
      if (b < nbytes) m[b*8 +: 8] = 8'hFF;
    return m;
  endfunction
endpackage

// File: rtl/bankreg_decode.sv
module bankreg_decode
  import bankreg_pkg::*;
#(
  parameter int A_W = AW,
  parameter int L_W = LW,
  parameter int D_W = DW
)(
  input  logic [A_W-1:0] addr,
  input  logic [L_W-1:0] lane,
  output logic           hit,
  output logic [D_W-1:0] bit_mask
);
  logic [D_W-1:0] lane_mask;
  logic [D_W-1:0] rsvd_keep;
  int             nbytes;

  always_comb begin
    nbytes    = slot_bytes(int'(addr));
    hit       = (nbytes != 0);
    lane_mask = D_W'(8'hFF) << {lane, 3'b000};
    rsvd_keep = (addr == '0) ? ~D_W'(RSVD0) : '1;
    bit_mask  = hit ? (lane_mask & width_mask(nbytes) & rsvd_keep) : '0;
  end
endmodule

// File: rtl/bankreg_profdet.sv
module bankreg_profdet #(
  parameter int PW = 3
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_strobe,
  input  logic [PW-1:0] profile_sel,
  output logic          xfer
);
  logic [PW-1:0] prof_q;

  always_ff @(posedge clk) begin
    if (rst) prof_q <= '0;
    else     prof_q <= profile_sel;
  end

  assign xfer = upd_strobe || (profile_sel != prof_q);
endmodule

// File: rtl/bankreg_flush.sv
module bankreg_flush #(
  parameter int LEN = 8
)(
  input  logic clk,
  input  logic rst,
  input  logic cmd,
  output logic busy,
  output logic done,
  output logic clr_pulse
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  logic [CW-1:0] cnt;

  assign done = busy && (cnt == CW'(LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      clr_pulse <= 1'b0;
    end else begin
      clr_pulse <= done;
      if (done) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end else if (cmd) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end
  end
endmodule

// File: rtl/bankreg_top.sv
module bankreg_top
  import bankreg_pkg::*;
#(
  parameter int N_SLOTS   = SLOTS,
  parameter int ADDR_W    = AW,
  parameter int DATA_W    = DW,
  parameter int LANE_W    = LW,
  parameter int PROF_W    = 3,
  parameter int FLUSH_LEN = 8
)(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [LANE_W-1:0]           wr_lane,
  input  logic [7:0]                  wr_data,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [DATA_W-1:0]           rd_data,
  input  logic                        upd_strobe,
  input  logic [PROF_W-1:0]           profile_sel,
  output logic [N_SLOTS*DATA_W-1:0]   act_regs,
  output logic                        flush_busy,
  output logic                        acc_clr
);
  logic [DATA_W-1:0] stg [N_SLOTS];
  logic [DATA_W-1:0] act [N_SLOTS];

  logic              wr_hit;
  logic [DATA_W-1:0] wr_mask;
  logic [DATA_W-1:0] wr_word;
  logic              xfer;
  logic              flush_done;
  logic              rd_hit;

  bankreg_decode #(.A_W(ADDR_W), .L_W(LANE_W), .D_W(DATA_W)) u_dec (
    .addr(wr_addr), .lane(wr_lane), .hit(wr_hit), .bit_mask(wr_mask)
  );

  bankreg_profdet #(.PW(PROF_W)) u_prof (
    .clk(clk), .rst(rst), .upd_strobe(upd_strobe),
    .profile_sel(profile_sel), .xfer(xfer)
  );

  bankreg_flush #(.LEN(FLUSH_LEN)) u_flush (
    .clk(clk), .rst(rst), .cmd(act[0][CMD_BIT]),
    .busy(flush_busy), .done(flush_done), .clr_pulse(acc_clr)
  );

  assign wr_word = DATA_W'(wr_data) << {wr_lane, 3'b000};
  assign rd_hit  = (slot_bytes(int'(rd_addr)) != 0) && (int'(rd_addr) < N_SLOTS);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_SLOTS; i++) begin
        stg[i] <= '0;
        act[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N_SLOTS; i++) begin
        if (xfer)
          act[i] <= stg[i];
        if (wr_en && wr_hit && (int'(wr_addr) == i))
          stg[i] <= (stg[i] & ~wr_mask) | (wr_word & wr_mask);
      end
      if (flush_done) begin
        stg[0][CMD_BIT] <= 1'b0;
        act[0][CMD_BIT] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_hit) rd_data <= stg[rd_addr];
    else             rd_data <= '0;
  end

  generate
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_flat
      assign act_regs[g*DATA_W +: DATA_W] = act[g];
    end
  endgenerate
endmodule

// File: rtl/bankreg_chk.sv
module bankreg_chk
  import bankreg_pkg::*;
#(
  parameter int N_SLOTS   = SLOTS,
  parameter int ADDR_W    = AW,
  parameter int DATA_W    = DW,
  parameter int PROF_W    = 3,
  parameter int FLUSH_LEN = 8
)(
  input logic                      clk,
  input logic                      rst,
  input logic [ADDR_W-1:0]         rd_addr,
  input logic [DATA_W-1:0]         rd_data,
  input logic                      upd_strobe,
  input logic [PROF_W-1:0]         profile_sel,
  input logic [N_SLOTS*DATA_W-1:0] act_regs,
  input logic                      flush_busy,
  input logic                      acc_clr
);
  logic [PROF_W-1:0] prof_d;
  logic              xfer_q;
  logic              rd_unused_q;
  logic [15:0]       run;

  always_ff @(posedge clk) begin
    if (rst) begin
      prof_d      <= '0;
      xfer_q      <= 1'b0;
      rd_unused_q <= 1'b0;
      run         <= '0;
    end else begin
      prof_d      <= profile_sel;
      xfer_q      <= upd_strobe || (profile_sel != prof_d);
      rd_unused_q <= (slot_bytes(int'(rd_addr)) == 0);
      run         <= flush_busy ? run + 1'b1 : '0;
    end
  end

  AST_UNUSED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_unused_q |-> rd_data == '0); // R1

  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!xfer_q && !acc_clr) |-> $stable(act_regs)); // R3

  AST_RSVD_NEVER_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (act_regs[31:0] & RSVD0) == 32'h0); // R7

  AST_BUSY_NOT_LONGER: assert property (@(posedge clk) disable iff (rst)
    flush_busy |-> run < 16'(FLUSH_LEN)); // R8

  AST_BUSY_EXACT_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(flush_busy) |-> run == 16'(FLUSH_LEN)); // R8

  AST_CLR_AT_END: assert property (@(posedge clk) disable iff (rst)
    acc_clr |-> $fell(flush_busy)); // R9

  AST_CMD_CLEARED: assert property (@(posedge clk) disable iff (rst)
    acc_clr |-> !act_regs[CMD_BIT]); // R9
endmodule

bind bankreg_top bankreg_chk #(
  .N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .PROF_W(PROF_W), .FLUSH_LEN(FLUSH_LEN)
) u_chk (
  .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
  .upd_strobe(upd_strobe), .profile_sel(profile_sel),
  .act_regs(act_regs), .flush_busy(flush_busy), .acc_clr(acc_clr)
);

// File: tb/bankreg_top_tb.sv
module bankreg_top_tb;
  localparam int NS  = 26;
  localparam int FL  = 8;
  localparam logic [31:0] RSV = 32'h6C1E_D000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [4:0]    wr_addr = '0;
  logic [1:0]    wr_lane = '0;
  logic [7:0]    wr_data = '0;
  logic [4:0]    rd_addr = '0;
  logic [31:0]   rd_data;
  logic          upd_strobe = 1'b0;
  logic [2:0]    profile_sel = '0;
  logic [NS*32-1:0] act_regs;
  logic          flush_busy;
  logic          acc_clr;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  bankreg_top u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_lane(wr_lane),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .upd_strobe(upd_strobe), .profile_sel(profile_sel), .act_regs(act_regs),
    .flush_busy(flush_busy), .acc_clr(acc_clr)
  );

  // behavioural reference
  logic [31:0] m_stg [NS];
  logic [31:0] m_act [NS];
  logic [31:0] m_rd;
  logic [2:0]  m_prof;
  logic        m_busy, m_clr;
  int          m_cnt;

  function automatic int nbytes(input int a);
    if (a == 7 || a == 8 || a == 11 || a == 12 || a == 13 || a == 23 || a > 25) return 0;
    if (a <= 2)  return 4;
    if (a <= 6)  return 2;
    if (a <= 10) return 4;
    if (a <= 21) return 3;
    if (a == 22) return 1;
    return 2;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NS; i++) begin m_stg[i] = 0; m_act[i] = 0; end
      m_rd = 0; m_prof = 0; m_busy = 0; m_clr = 0; m_cnt = 0;
    end else begin
      logic [31:0] old_stg [NS];
      logic old_cmd, ending;
      for (int i = 0; i < NS; i++) old_stg[i] = m_stg[i];
      old_cmd = m_act[0][21];
      ending  = m_busy && (m_cnt == FL - 1);
      m_rd = (nbytes(int'(rd_addr)) != 0) ? old_stg[rd_addr] : 32'h0;
      if (upd_strobe || profile_sel != m_prof)
        for (int i = 0; i < NS; i++) m_act[i] = old_stg[i];
      m_prof = profile_sel;
      if (wr_en && int'(wr_lane) < nbytes(int'(wr_addr))) begin
        logic [7:0] b;
        b = wr_data;
        if (wr_addr == 0) b = b & ~RSV[wr_lane*8 +: 8];
        m_stg[wr_addr][wr_lane*8 +: 8] = b;
      end
      m_clr = ending;
      if (ending) begin
        m_stg[0][21] = 1'b0; m_act[0][21] = 1'b0; m_busy = 0; m_cnt = 0;
      end else if (m_busy) m_cnt++;
      else if (old_cmd) begin m_busy = 1; m_cnt = 0; end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk("R6 rd_data", rd_data, m_rd);
      chk("R8 flush_busy", 32'(flush_busy), 32'(m_busy));
      chk("R9 acc_clr", 32'(acc_clr), 32'(m_clr));
      for (int i = 0; i < NS; i++)
        chk("R3 active copy", act_regs[i*32 +: 32], m_act[i]);
    end
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wbyte(input int a, input int l, input logic [7:0] d);
    wr_en = 1; wr_addr = 5'(a); wr_lane = 2'(l); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic upd();
    upd_strobe = 1; @(negedge clk); upd_strobe = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    rd_addr = 5'(a); @(negedge clk); v = rd_data;
  endtask

  initial begin
    logic [31:0] v;
    int nb, nc;
    idle(3);
    // R10: reset state
    chk("R10 rd_data", rd_data, 32'h0);
    chk("R10 busy", 32'(flush_busy), 32'h0);
    chk("R10 act slot0", act_regs[31:0], 32'h0);
    rst = 0;
    idle(1);

    // R3 / R6 staging and readback
    wbyte(1, 0, 8'h11); wbyte(1, 1, 8'h22); wbyte(1, 2, 8'h33); wbyte(1, 3, 8'h44);
    rd(1, v); chk("R6 staged readback", v, 32'h44332211);
    chk("R3 active untouched", act_regs[1*32 +: 32], 32'h0);
    upd(); idle(1);
    chk("R4 transfer", act_regs[1*32 +: 32], 32'h44332211);

    // R2 widths
    wbyte(3, 2, 8'hAA); wbyte(3, 0, 8'h5A);
    rd(3, v); chk("R2 lane beyond width", v, 32'h0000005A);
    wbyte(22, 1, 8'hBB); wbyte(22, 0, 8'h3C);
    rd(22, v); chk("R2 one-byte slot", v, 32'h0000003C);

    // R1 unused addresses
    wbyte(7, 0, 8'hFF); wbyte(23, 1, 8'hFF); wbyte(12, 0, 8'hFF);
    rd(7, v);  chk("R1 unused read 7", v, 32'h0);
    rd(23, v); chk("R1 unused read 23", v, 32'h0);
    rd(30, v); chk("R1 read above map", v, 32'h0);
    upd(); idle(1);
    chk("R1 unused active", act_regs[7*32 +: 32] | act_regs[23*32 +: 32], 32'h0);

    // R7 reserved bits of slot 0
    wbyte(0, 3, 8'hFF); wbyte(0, 2, 8'hDF); wbyte(0, 1, 8'hFF);
    rd(0, v); chk("R7 reserved masked", v, 32'h93C12F00);

    // R4 write and update in the same cycle
    wr_en = 1; wr_addr = 5'd2; wr_lane = 0; wr_data = 8'h77; upd_strobe = 1;
    @(negedge clk); wr_en = 0; upd_strobe = 0;
    chk("R4 same-cycle write not transferred", act_regs[2*32 +: 32], 32'h0);
    chk("R7 active slot0", act_regs[31:0], 32'h93C12F00);
    rd(2, v); chk("R4 same-cycle write staged", v, 32'h77);

    // R5 profile change
    profile_sel = 3'd3; @(negedge clk);
    chk("R5 profile change transfers", act_regs[2*32 +: 32], 32'h77);
    wbyte(2, 0, 8'h78); idle(3);
    chk("R5 steady profile no transfer", act_regs[2*32 +: 32], 32'h77);

    // R8 / R9 flush, with an update landing mid-flush
    wbyte(0, 2, 8'hE1);
    rd(0, v); chk("R8 command staged", v, 32'h93E12F00);
    upd_strobe = 1; @(negedge clk); upd_strobe = 0;
    nb = 0; nc = 0;
    for (int k = 0; k < 14; k++) begin
      if (k == 4) upd_strobe = 1;
      @(negedge clk);
      upd_strobe = 0;
      if (flush_busy) nb++;
      if (acc_clr) begin
        nc++;
        chk("R9 active cmd cleared", act_regs[31:0], 32'h93C12F00);
      end
    end
    chk("R8 busy length", 32'(nb), 32'(FL));
    chk("R9 single clear pulse", 32'(nc), 32'h1);
    rd(0, v); chk("R9 staged cmd cleared", v, 32'h93C12F00);

    // R9 update on the ending edge: clear wins
    wbyte(0, 2, 8'hE1); upd();
    idle(FL - 1);
    wbyte(0, 2, 8'hE1);
    upd_strobe = 1; @(negedge clk); upd_strobe = 0;
    idle(2);
    chk("R9 end-edge priority busy", 32'(flush_busy), 32'(m_busy));

    // R5 change back; R10 second reset
    profile_sel = 3'd0; idle(12);
    rst = 1; idle(2);
    chk("R10 reset clears active", act_regs[31:0] | act_regs[32 +: 32], 32'h0);
    chk("R10 reset busy", 32'(flush_busy), 32'h0);
    rst = 0; idle(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule